// File: doc/BRIEF.md
# Table-Loaded Channel Length Counter

This block decides how long an audio channel keeps sounding. When software writes the channel's length register, the five upper data bits select one entry of a fixed 32-entry table. The index passes through a full one-hot decoder into 32 select rows. A wired-OR plane then turns the single active row into an 8-bit starting count. Each stored count is one less than the nominal length, so the channel goes quiet on the tick that brings the count to zero.

After a load, the counter steps down by one on each cycle where the periodic tick enable is high. It stops at zero and does not wrap. While the count is zero, the silence output is high. Clearing the channel enable empties the counter and blocks new loads. The source of the tick and the waveform being gated are outside this block.

Top module: `lc_length_counter`

## Requirements
- R1: After the asynchronous active-low reset, count_o is 0 and silence_o is 1.
- R2: The table index is data_i[7:3]. row_o has exactly one bit set, at position data_i[7:3], and it follows data_i combinationally.
- R3: A write with index 0, 2, 4 or 6 loads 9, 19, 39 or 79. The value appears on count_o in the cycle after the write edge.
- R4: For each other index, an even index 2k loads (B << (k mod 4)) - 1, where B is 10, 12, 14 or 16 for k/4 = 0, 1, 2 or 3. An odd index 2k+1 loads 8k+7.
- R5: With en_i high, no write, and a nonzero count, a cycle with tick_i high lowers the count by exactly 1. A cycle with tick_i low leaves the count unchanged.
- R6: A tick while the count is 0 leaves it at 0. The count never wraps.
- R7: silence_o is 1 exactly when count_o is 0.
- R8: While en_i is low, the count becomes 0 at the next edge, and writes have no effect.
- R9: When a write and a tick come in the same cycle with en_i high, the table value is loaded and the tick is discarded.
- R10: data_i[2:0] has no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the length register |
| data_i | input | 8 | Write data; bits 7:3 are the table index |
| tick_i | input | 1 | Decrement enable |
| en_i | input | 1 | Channel enable |
| count_o | output | 8 | Current count |
| silence_o | output | 1 | High while the count is zero |
| row_o | output | 32 | One-hot decoder rows for the current data_i |

## Verification
The hardest case to reach is a count that has been ticked all the way down to zero, with further ticks arriving after that. Random traffic reloads the counter too often for this to happen, even with short table entries. A directed sequence therefore loads index 0 and issues exactly ten ticks with no writes, then sends more ticks while watching for a wrap. Collisions between a write and a tick, and writes made while the channel is disabled, are drawn deliberately in the random phase.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int IDX_W  = 5;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam int IDX_LSB = 3;
  localparam int ROWS   = 1 << IDX_W;

  // Stored value = nominal length - 1.
  function automatic logic [CNT_W-1:0] lc_rom_word(input logic [IDX_W-1:0] idx);
    logic [3:0]       k;
    logic [CNT_W-1:0] base;
    k = idx[4:1];
    if (idx[0]) begin
      return {1'b0, k, 3'b111};
    end
    base = CNT_W'(10) + CNT_W'({k[3:2], 1'b0});
    return (base << k[1:0]) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/lc_row_decoder.sv
module lc_row_decoder
  import lc_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [ROWS-1:0]  row_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_o[r] = (idx_i == IDX_W'(r));
  end
endmodule

// File: rtl/lc_or_plane.sv
module lc_or_plane
  import lc_pkg::*;
(
  input  logic [ROWS-1:0]  row_i,
  output logic [CNT_W-1:0] word_o
);
  logic [CNT_W-1:0] contrib [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_cell
    localparam logic [CNT_W-1:0] CELL = lc_rom_word(IDX_W'(r));
    assign contrib[r] = row_i[r] ? CELL : '0;
  end

  always_comb begin
    word_o = '0;
    for (int r = 0; r < ROWS; r++) word_o = word_o | contrib[r];
  end
endmodule

// File: rtl/lc_down_counter.sv
module lc_down_counter
  import lc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                        cnt_d = '0;
    else if (load_i)                  cnt_d = load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lc_length_counter.sv
module lc_length_counter
  import lc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  input  logic              en_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              silence_o,
  output logic [ROWS-1:0]   row_o
);
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] rom_word;

  assign idx = data_i[IDX_LSB +: IDX_W];

  lc_row_decoder u_dec (.idx_i(idx), .row_o(row_o));
  lc_or_plane    u_rom (.row_i(row_o), .word_o(rom_word));

  lc_down_counter u_cnt (
    .clk_i, .rst_ni, .en_i,
    .load_i    (wr_i),
    .load_val_i(rom_word),
    .tick_i,
    .cnt_o     (count_o)
  );

  assign silence_o = (count_o == '0);
endmodule

// File: rtl/lc_length_counter_chk.sv
module lc_length_counter_chk
  import lc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              tick_i,
  input logic              en_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              silence_o,
  input logic [ROWS-1:0]   row_o
);
  a_r2_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_o) == 1);

  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i && tick_i && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1));

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !(wr_i && en_i)) |=> count_o == '0);

  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> silence_o);

  a_r9_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> !silence_o);
endmodule

bind lc_length_counter lc_length_counter_chk u_chk (
  .clk_i, .rst_ni, .wr_i, .tick_i, .en_i, .count_o, .silence_o, .row_o
);

// File: tb/lc_length_counter_bench.sv
module lc_length_counter_bench;
  logic        clk_i = 0, rst_ni = 0, wr_i = 0, tick_i = 0, en_i = 0;
  logic [7:0]  data_i = 0;
  logic [7:0]  count_o;
  logic        silence_o;
  logic [31:0] row_o;
  int checks = 0, errors = 0;
  logic [7:0] model = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  lc_length_counter u_lc_length_counter (.*);

  function automatic logic [7:0] exp_word(input logic [4:0] idx);
    int k, b;
    k = idx >> 1;
    if (idx[0]) return 8'(8 * k + 7);
    case (k / 4)
      0: b = 10; 1: b = 12; 2: b = 14; default: b = 16;
    endcase
    return 8'((b << (k % 4)) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, compare after it
  task automatic step(input logic wr, input logic [7:0] d, input logic tk, input logic en,
                      input string req);
    @(negedge clk_i);
    wr_i = wr; data_i = d; tick_i = tk; en_i = en;
    #1 chk("R2", row_o, 32'd1 << d[7:3]);
    if (!en)           model = 0;
    else if (wr)       model = exp_word(d[7:3]);
    else if (tk && model != 0) model = model - 1;
    @(posedge clk_i); #1;
    chk(req, count_o, model);
    chk("R7", silence_o, model == 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #12;
    chk("R1", count_o, 0);
    chk("R1", silence_o, 1);
    rst_ni = 1;
    // R3 directed
    step(1, 8'h00, 0, 1, "R3"); chk("R3", count_o, 9);
    step(1, 8'h10, 0, 1, "R3"); chk("R3", count_o, 19);
    step(1, 8'h20, 0, 1, "R3"); chk("R3", count_o, 39);
    step(1, 8'h30, 0, 1, "R3"); chk("R3", count_o, 79);
    // R4 and R10: whole table, low bits varied
    for (int i = 0; i < 32; i++) step(1, 8'((i << 3) | (i % 8)), 0, 1, "R4");
    step(1, 8'h07, 0, 1, "R10"); chk("R10", count_o, 9);
    // R5/R6: run index 0 down to zero and beyond
    for (int i = 0; i < 9; i++) step(0, 8'h00, 1, 1, "R5");
    step(0, 8'h00, 0, 1, "R5");
    step(0, 8'h00, 1, 1, "R5"); chk("R6", count_o, 0);
    for (int i = 0; i < 3; i++) step(0, 8'hff, 1, 1, "R6");
    chk("R6", count_o, 0);
    // R9 collision
    step(1, 8'h30, 1, 1, "R9"); chk("R9", count_o, 79);
    // R8 disable clears and blocks loads
    step(0, 8'h00, 0, 0, "R8"); chk("R8", count_o, 0);
    step(1, 8'h38, 1, 0, "R8"); chk("R8", count_o, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w, t, e;
      w = ($urandom % 8) == 0;
      t = ($urandom % 2) == 0;
      e = ($urandom % 40) != 0;
      step(w, 8'($urandom), t, e, "R5");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule